// File: doc/BRIEF.md
# Pipelined Flit Payload Compression Encoder

This block sits in the sender network interface of an on-chip network tile. A packet arrives as one head flit, which carries the address, followed by up to eight 64-bit payload flits. A destination PE number and a compression-enable flag come with the head. Each payload flit is looked up in a shared value table. When the value is present and the table holds a valid index for that destination, the flit is dropped from the stream. Its short index is then carried in a packed trailing flit, together with the sequence number of the flit it replaces. Payload flits that do not match are sent unchanged, ahead of the packed flit, so the receiver gets a shorter packet and can still rebuild the original order.

The table has a fixed number of entries. Each entry holds one 64-bit value and one index element per destination PE, and each element has its own valid bit. Only commands from receivers change the table. An insert command publishes a value and its index for one receiver. An invalidate command withdraws a receiver's index and returns an acknowledge. Lookup is split over two register stages, and a third stage builds the outgoing flits. This stage lets the head flit and unmatched flits leave while later payload flits are still being looked up.

Top module: `flit_cmp_encoder`

## Requirements
- R1: The head flit is the first output flit of every packet. It has status bit 0 and its data is unchanged, even if its value is present in the table.
- R2: A payload flit is replaced by an index only when compression is enabled, an entry holds its value, and that entry's element for the packet's destination is valid. Any other payload flit is output unchanged with status 0.
- R3: Unencoded payload flits leave in their original relative order. When at least one payload flit was encoded, one packed flit with status 1 follows them and carries the packet's last marker. When none was encoded, the last unencoded flit carries the last marker. No other flits are output.
- R4: Packed flit layout: bits [63:60] hold the number of pairs. Pair k occupies bits [7k+6:7k], with the 3-bit index in the low bits [7k+2:7k] and the 4-bit sequence id in [7k+6:7k+3]. The sequence id is the payload position counted from 0 after the head. Pairs appear in arrival order, and every unused bit is 0.
- R5: When the compression enable is low with the head flit, the whole packet is output unmodified, with every status bit 0.
- R6: An insert command (op 0) for a value already held sets that receiver's index element in the existing entry. For a new value, it takes a free entry. When all entries are in use, an insert of a new value has no effect.
- R7: An invalidate command (op 1) clears the receiver's index element for that value. One cycle later it raises the acknowledge together with the receiver's PE number. An entry whose elements are all cleared becomes free.
- R8: Table contents change only on commands. The same packet sent twice without commands in between produces the same output.
- R9: With the output ready held high and the pipeline empty, a head flit accepted at a clock edge is presented at the output after the second following edge.
- R10: While the output is valid and not ready, the output data, status and last marker hold steady. No flit is lost or duplicated under back-pressure.
- R11: After reset, no output flit and no acknowledge is presented, and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit accepted at this edge when valid |
| in_data | input | 64 | Input flit data |
| in_last | input | 1 | Marks the final flit of the input packet |
| in_dest | input | 4 | Destination PE, sampled with the head flit |
| in_comp_en | input | 1 | Compression enable, sampled with the head flit |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream accepts the output flit |
| out_data | output | 64 | Output flit data |
| out_last | output | 1 | Marks the final flit of the output packet |
| out_enc | output | 1 | Status: 0 raw data, 1 packed indices |
| cmd_valid | input | 1 | Table command valid |
| cmd_op | input | 1 | 0 insert, 1 invalidate |
| cmd_pe | input | 4 | Receiver PE issuing the command |
| cmd_value | input | 64 | Value the command refers to |
| cmd_index | input | 3 | Index assigned by the receiver (insert) |
| ack_valid | output | 1 | Invalidate acknowledge |
| ack_pe | output | 4 | Receiver PE being acknowledged |

## Verification
Directed packets cover several cases: the worked case of three matches among four payload flits, and a packet in which every payload flit matches and the packed flit is full. Other directed packets cover a lone head, a head whose value is in the table, and a packet whose values are published only for another destination. Each of these separates a distinct decision: whether the head is exempt, whether the destination element gates a match, where the last marker lands, and how the pair count is encoded. The same values sent with compression disabled, and sent again after a full-table insert or an invalidate, show whether the enable and the command rules really steer the lookup. Random packets with random back-pressure and random commands in between exercise the ordering of raw and packed flits under stalls.

// File: rtl/flit_cmp_pkg.sv
package flit_cmp_pkg;
    localparam int DEF_PES     = 16;
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_FLIT_W  = 64;
    localparam int DEF_IDX_W   = 3;
    localparam int DEF_SEQ_W   = 4;
    localparam int DEF_MAX_PAY = 8;

    typedef enum logic {
        OP_INSERT = 1'b0,
        OP_INVAL  = 1'b1
    } cmd_op_e;
endpackage

// File: rtl/flit_cmp_table.sv
module flit_cmp_table
    import flit_cmp_pkg::*;
#(
    parameter int NUM_PE  = DEF_PES,
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int FLIT_W  = DEF_FLIT_W,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int PE_W    = $clog2(NUM_PE),
    parameter int ENT_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_op,
    input  logic [PE_W-1:0]     cmd_pe,
    input  logic [FLIT_W-1:0]   cmd_value,
    input  logic [IDX_W-1:0]    cmd_index,
    output logic                ack_valid,
    output logic [PE_W-1:0]     ack_pe,
    input  logic [FLIT_W-1:0]   lk_value,
    output logic [ENTRIES-1:0]  lk_match,
    input  logic [ENTRIES-1:0]  rs_match,
    input  logic [PE_W-1:0]     rs_dest,
    output logic                rs_hit,
    output logic [IDX_W-1:0]    rs_idx
);
    typedef struct packed {
        logic [ENTRIES-1:0][FLIT_W-1:0]            val;
        logic [ENTRIES-1:0][NUM_PE-1:0]            iv;
        logic [ENTRIES-1:0][NUM_PE-1:0][IDX_W-1:0] idx;
        logic                                      ack;
        logic [PE_W-1:0]                           ack_pe;
    } tbl_t;

    tbl_t               st_q, st_d;
    logic [ENTRIES-1:0] used;
    logic [ENTRIES-1:0] cmd_hit;
    logic               free_ok;
    logic [ENT_W-1:0]   free_e;

    // an entry is in use while any receiver still publishes an index for it
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            used[e]     = |st_q.iv[e];
            cmd_hit[e]  = used[e] && (st_q.val[e] == cmd_value);
            lk_match[e] = used[e] && (st_q.val[e] == lk_value);
        end
        free_ok = 1'b0;
        free_e  = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!used[e]) begin
                free_ok = 1'b1;
                free_e  = ENT_W'(e);
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (cmd_valid) begin
            if (cmd_op_e'(cmd_op) == OP_INSERT) begin
                if (|cmd_hit) begin
                    for (int e = 0; e < ENTRIES; e++) begin
                        if (cmd_hit[e]) begin
                            st_d.iv[e][cmd_pe]  = 1'b1;
                            st_d.idx[e][cmd_pe] = cmd_index;
                        end
                    end
                end else if (free_ok) begin
                    st_d.val[free_e]         = cmd_value;
                    st_d.iv[free_e][cmd_pe]  = 1'b1;
                    st_d.idx[free_e][cmd_pe] = cmd_index;
                end
            end else begin
                for (int e = 0; e < ENTRIES; e++) begin
                    if (cmd_hit[e]) begin
                        st_d.iv[e][cmd_pe] = 1'b0;
                    end
                end
                st_d.ack    = 1'b1;
                st_d.ack_pe = cmd_pe;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // second lookup stage: gate the registered CAM match by the destination element
    always_comb begin
        rs_hit = 1'b0;
        rs_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (rs_match[e] && st_q.iv[e][rs_dest]) begin
                rs_hit = 1'b1;
                rs_idx = rs_idx | st_q.idx[e][rs_dest];
            end
        end
    end

    assign ack_valid = st_q.ack;
    assign ack_pe    = st_q.ack_pe;

    AST_CAM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R6
    AST_INV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INVAL) |=> (ack_valid && ack_pe == $past(cmd_pe))); // R7
    AST_QUIET_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(st_q.val) && $stable(st_q.iv) && $stable(st_q.idx))); // R8
endmodule

// File: rtl/flit_cmp_packer.sv
module flit_cmp_packer
    import flit_cmp_pkg::*;
#(
    parameter int FLIT_W  = DEF_FLIT_W,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int SEQ_W   = DEF_SEQ_W,
    parameter int MAX_PAY = DEF_MAX_PAY,
    parameter int PAIR_W  = IDX_W + SEQ_W,
    parameter int CNT_W   = $clog2(MAX_PAY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_v,
    input  logic              s2_head,
    input  logic              s2_last,
    input  logic              s2_hit,
    input  logic [SEQ_W-1:0]  s2_seq,
    input  logic [IDX_W-1:0]  s2_idx,
    input  logic [FLIT_W-1:0] s2_data,
    output logic              take_o,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_data,
    output logic              out_last,
    output logic              out_enc
);
    localparam int PACK_W = PAIR_W * MAX_PAY;

    typedef struct packed {
        logic              ov;
        logic              olast;
        logic              oenc;
        logic [FLIT_W-1:0] odata;
        logic              pend;
        logic [CNT_W-1:0]  cnt;
        logic [PACK_W-1:0] pairs;
    } pk_t;

    pk_t               st_q, st_d;
    logic              adv;
    logic [PACK_W-1:0] new_pairs;
    logic [CNT_W-1:0]  new_cnt;

    function automatic logic [FLIT_W-1:0] pack_word(input logic [CNT_W-1:0] c,
                                                     input logic [PACK_W-1:0] p);
        logic [FLIT_W-1:0] w;
        w = '0;
        w[FLIT_W-1 -: CNT_W] = c;
        w[PACK_W-1:0]        = p;
        return w;
    endfunction

    always_comb begin
        adv    = !st_q.ov || out_ready;
        take_o = adv && !st_q.pend;

        new_pairs = st_q.pairs;
        for (int k = 0; k < MAX_PAY; k++) begin
            if (st_q.cnt == CNT_W'(k)) begin
                new_pairs[k*PAIR_W +: PAIR_W] = {s2_seq, s2_idx};
            end
        end
        new_cnt = st_q.cnt + CNT_W'(1);

        st_d = st_q;
        if (adv) begin
            st_d.ov = 1'b0;
        end
        if (st_q.pend && adv) begin
            // second flit owed by a raw last flit: emit the packed indices
            st_d.ov    = 1'b1;
            st_d.odata = pack_word(st_q.cnt, st_q.pairs);
            st_d.olast = 1'b1;
            st_d.oenc  = 1'b1;
            st_d.pend  = 1'b0;
            st_d.cnt   = '0;
            st_d.pairs = '0;
        end else if (take_o && s2_v) begin
            if (s2_head) begin
                st_d.ov    = 1'b1;
                st_d.odata = s2_data;
                st_d.olast = s2_last;
                st_d.oenc  = 1'b0;
                st_d.cnt   = '0;
                st_d.pairs = '0;
            end else if (s2_hit) begin
                if (s2_last) begin
                    st_d.ov    = 1'b1;
                    st_d.odata = pack_word(new_cnt, new_pairs);
                    st_d.olast = 1'b1;
                    st_d.oenc  = 1'b1;
                    st_d.cnt   = '0;
                    st_d.pairs = '0;
                end else begin
                    st_d.cnt   = new_cnt;
                    st_d.pairs = new_pairs;
                end
            end else begin
                st_d.ov    = 1'b1;
                st_d.odata = s2_data;
                st_d.oenc  = 1'b0;
                st_d.olast = s2_last && (st_q.cnt == '0);
                st_d.pend  = s2_last && (st_q.cnt != '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.odata;
    assign out_last  = st_q.olast;
    assign out_enc   = st_q.oenc;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_enc))); // R10
    AST_PACK_IS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_enc) |-> out_last); // R3
    AST_PACK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_enc) |-> (out_data[FLIT_W-1 -: CNT_W] != '0)); // R4
endmodule

// File: rtl/flit_cmp_encoder.sv
module flit_cmp_encoder
    import flit_cmp_pkg::*;
#(
    parameter int NUM_PE  = DEF_PES,
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int FLIT_W  = DEF_FLIT_W,
    parameter int IDX_W   = DEF_IDX_W,
    parameter int SEQ_W   = DEF_SEQ_W,
    parameter int MAX_PAY = DEF_MAX_PAY,
    parameter int PE_W    = $clog2(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_data,
    input  logic              in_last,
    input  logic [PE_W-1:0]   in_dest,
    input  logic              in_comp_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLIT_W-1:0] out_data,
    output logic              out_last,
    output logic              out_enc,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [PE_W-1:0]   cmd_pe,
    input  logic [FLIT_W-1:0] cmd_value,
    input  logic [IDX_W-1:0]  cmd_index,
    output logic              ack_valid,
    output logic [PE_W-1:0]   ack_pe
);
    typedef struct packed {
        logic              v;
        logic              head;
        logic              last;
        logic              en;
        logic [PE_W-1:0]   dest;
        logic [SEQ_W-1:0]  seq;
        logic [FLIT_W-1:0] data;
    } s1_t;

    typedef struct packed {
        logic              v;
        logic              head;
        logic              last;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [SEQ_W-1:0]  seq;
        logic [FLIT_W-1:0] data;
    } s2_t;

    typedef struct packed {
        s1_t                s1;
        logic [ENTRIES-1:0] m1;
        s2_t                s2;
        logic               at_head;
        logic               en;
        logic [PE_W-1:0]    dest;
        logic [SEQ_W-1:0]   seq;
    } top_t;

    top_t               st_q, st_d;
    logic               move;
    logic [ENTRIES-1:0] lk_match;
    logic               rs_hit;
    logic [IDX_W-1:0]   rs_idx;

    flit_cmp_table #(
        .NUM_PE (NUM_PE),
        .ENTRIES(ENTRIES),
        .FLIT_W (FLIT_W),
        .IDX_W  (IDX_W)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_pe   (cmd_pe),
        .cmd_value(cmd_value),
        .cmd_index(cmd_index),
        .ack_valid(ack_valid),
        .ack_pe   (ack_pe),
        .lk_value (in_data),
        .lk_match (lk_match),
        .rs_match (st_q.m1),
        .rs_dest  (st_q.s1.dest),
        .rs_hit   (rs_hit),
        .rs_idx   (rs_idx)
    );

    flit_cmp_packer #(
        .FLIT_W (FLIT_W),
        .IDX_W  (IDX_W),
        .SEQ_W  (SEQ_W),
        .MAX_PAY(MAX_PAY)
    ) i_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .s2_v     (st_q.s2.v),
        .s2_head  (st_q.s2.head),
        .s2_last  (st_q.s2.last),
        .s2_hit   (st_q.s2.hit),
        .s2_seq   (st_q.s2.seq),
        .s2_idx   (st_q.s2.idx),
        .s2_data  (st_q.s2.data),
        .take_o   (move),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_last (out_last),
        .out_enc  (out_enc)
    );

    always_comb begin
        st_d = st_q;
        if (move) begin
            // stage 1: capture flit with packet context and the CAM match
            st_d.s1.v    = in_valid;
            st_d.s1.head = st_q.at_head;
            st_d.s1.last = in_last;
            st_d.s1.data = in_data;
            st_d.s1.en   = st_q.at_head ? in_comp_en : st_q.en;
            st_d.s1.dest = st_q.at_head ? in_dest    : st_q.dest;
            st_d.s1.seq  = st_q.at_head ? '0         : st_q.seq;
            st_d.m1      = lk_match;
            if (in_valid) begin
                st_d.at_head = in_last;
                if (st_q.at_head) begin
                    st_d.en   = in_comp_en;
                    st_d.dest = in_dest;
                    st_d.seq  = '0;
                end else begin
                    st_d.seq  = st_q.seq + SEQ_W'(1);
                end
            end
            // stage 2: destination-gated hit; the head never qualifies
            st_d.s2.v    = st_q.s1.v;
            st_d.s2.head = st_q.s1.head;
            st_d.s2.last = st_q.s1.last;
            st_d.s2.seq  = st_q.s1.seq;
            st_d.s2.data = st_q.s1.data;
            st_d.s2.hit  = st_q.s1.v && !st_q.s1.head && st_q.s1.en && rs_hit;
            st_d.s2.idx  = rs_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.at_head <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = move;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !ack_valid)); // R11
endmodule

// File: tb/test_flit_cmp_encoder.sv
module test_flit_cmp_encoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [3:0]  in_dest = '0;
    logic        in_comp_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic        out_last;
    logic        out_enc;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic [3:0]  cmd_pe = '0;
    logic [63:0] cmd_value = '0;
    logic [2:0]  cmd_index = '0;
    logic        ack_valid;
    logic [3:0]  ack_pe;

    flit_cmp_encoder i_flit_cmp_encoder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_dest(in_dest), .in_comp_en(in_comp_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_enc(out_enc),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pe(cmd_pe),
        .cmd_value(cmd_value), .cmd_index(cmd_index),
        .ack_valid(ack_valid), .ack_pe(ack_pe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] m_val [8];
    logic [15:0] m_iv  [8];
    logic [2:0]  m_idx [8][16];
    logic [63:0] pk [0:8];
    logic [65:0] exp_q [$];
    bit          rdy_rand = 1'b0;
    int unsigned acc_cyc, out_cyc;

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] val(input int k);
        return 64'h0123_4567_89AB_0000 + 64'(k) * 64'h0000_0101_0001_0003;
    endfunction

    function automatic void look(input logic [63:0] v, input int d,
                                 output bit hit, output logic [2:0] ix);
        hit = 1'b0;
        ix  = '0;
        for (int e = 0; e < 8; e++) begin
            if (m_iv[e] != 0 && m_val[e] == v && m_iv[e][d]) begin
                hit = 1'b1;
                ix  = m_idx[e][d];
            end
        end
    endfunction

    // caller stands at a falling edge; returns at a falling edge
    task automatic cmd(input bit op, input int pe, input logic [63:0] v, input logic [2:0] ix);
        int fe;
        cmd_valid = 1'b1; cmd_op = op; cmd_pe = 4'(pe); cmd_value = v; cmd_index = ix;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R7 ack", {61'b0, ack_valid, ack_pe}, {61'b0, op, (op ? 4'(pe) : ack_pe)});
        fe = -1;
        for (int e = 0; e < 8; e++) if (m_iv[e] != 0 && m_val[e] == v) fe = e;
        if (op == 1'b0) begin
            if (fe < 0) for (int e = 7; e >= 0; e--) if (m_iv[e] == 0) fe = e;
            if (fe >= 0) begin
                m_val[fe] = v; m_iv[fe][pe] = 1'b1; m_idx[fe][pe] = ix;
            end
        end else if (fe >= 0) begin
            m_iv[fe][pe] = 1'b0;
        end
    endtask

    task automatic send(input int np, input int dest, input bit en, input bit lat, input string req);
        bit          hit;
        logic [2:0]  ix;
        logic [55:0] pairs = '0;
        int          cnt = 0;
        bit          seen = 1'b0;
        exp_q.push_back({1'b0, (np == 0), pk[0]});
        for (int i = 1; i <= np; i++) begin
            look(pk[i], dest, hit, ix);
            if (en && hit) begin
                pairs[cnt*7 +: 7] = {4'(i - 1), ix};
                cnt++;
            end else begin
                exp_q.push_back({2'b00, pk[i]});
            end
        end
        if (cnt > 0) exp_q.push_back({2'b11, 4'(cnt), 4'b0, pairs});
        else exp_q[$][64] = 1'b1;
        fork
            begin
                for (int i = 0; i <= np; i++) begin
                    bit hs;
                    in_valid = 1'b1; in_data = pk[i]; in_last = (i == np);
                    in_dest = 4'(dest); in_comp_en = en;
                    do begin
                        #1 hs = in_ready;
                        @(posedge clk);
                        @(negedge clk);
                    end while (!hs);
                    if (i == 0) acc_cyc = cyc;
                end
                in_valid = 1'b0;
            end
            begin
                while (exp_q.size() > 0) begin
                    @(negedge clk);
                    out_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
                    #1;
                    if (out_valid && !seen) begin seen = 1'b1; out_cyc = cyc; end
                    if (out_valid && out_ready) begin
                        logic [65:0] e;
                        e = exp_q.pop_front();
                        check(req, {out_enc, out_last, out_data}, e);
                    end
                end
            end
        join
        @(negedge clk);
        if (lat) check("R9 latency", 66'(out_cyc - acc_cyc), 66'd2);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 no extra flit", {65'b0, out_valid}, 66'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int e = 0; e < 8; e++) begin
            m_val[e] = '0; m_iv[e] = '0;
            for (int p = 0; p < 16; p++) m_idx[e][p] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 reset", {63'b0, in_ready, out_valid, ack_valid}, {63'b0, 3'b100});
        @(negedge clk);

        for (int k = 0; k < 4; k++) cmd(1'b0, 5, val(k), 3'(k));
        cmd(1'b0, 2, val(1), 3'd6);

        // R1 R3 R4 R9: head value in table stays raw; three of four payload flits packed
        pk[0] = val(0); pk[1] = val(9); pk[2] = val(1); pk[3] = val(2); pk[4] = val(3);
        send(4, 5, 1'b1, 1'b1, "R1 R3 R4 worked packet");
        // R8: identical packet, no commands in between
        send(4, 5, 1'b1, 1'b1, "R8 repeat packet");
        // R5: bypass
        send(4, 5, 1'b0, 1'b0, "R5 bypass");
        // R2: destination element gates the hit
        pk[1] = val(0); pk[2] = val(1); pk[3] = val(3);
        send(3, 2, 1'b1, 1'b0, "R2 other destination");
        // R4: full packed flit
        for (int i = 1; i <= 8; i++) pk[i] = val((i * 3) % 4);
        send(8, 5, 1'b1, 1'b0, "R4 eight pairs");
        // R1: lone head
        send(0, 5, 1'b1, 1'b0, "R1 lone head");
        // R3: raw last flit after packed ones
        pk[1] = val(1); pk[2] = val(10);
        send(2, 5, 1'b1, 1'b0, "R3 raw last");

        // R6: fill the table, then a new value is refused
        for (int k = 4; k < 8; k++) cmd(1'b0, 5, val(k), 3'(k));
        cmd(1'b0, 5, val(8), 3'd1);
        pk[1] = val(8); pk[2] = val(7);
        send(2, 5, 1'b1, 1'b0, "R6 full table insert");
        cmd(1'b0, 9, val(0), 3'd4);
        pk[1] = val(0);
        send(1, 9, 1'b1, 1'b0, "R6 existing value new receiver");

        // R7: invalidate one receiver, others keep it
        cmd(1'b1, 5, val(0), 3'd0);
        send(1, 5, 1'b1, 1'b0, "R7 invalidated receiver");
        send(1, 9, 1'b1, 1'b0, "R7 other receiver kept");
        cmd(1'b1, 9, val(0), 3'd0);
        cmd(1'b0, 5, val(8), 3'd2);
        pk[1] = val(8);
        send(1, 5, 1'b1, 1'b0, "R7 freed entry reused");

        // R10 R2: random packets under back-pressure with commands between them
        rdy_rand = 1'b1;
        for (int n = 0; n < 60; n++) begin
            int np;
            int dsel;
            np = $urandom_range(0, 8);
            for (int i = 0; i <= np; i++) pk[i] = val($urandom_range(0, 11));
            dsel = $urandom_range(0, 3);
            send(np, (dsel == 0) ? 2 : (dsel == 1) ? 5 : (dsel == 2) ? 9 : 12,
                 ($urandom_range(0, 3) != 0), 1'b0, "R10 random");
            if ($urandom_range(0, 1) == 1)
                cmd($urandom_range(0, 2) == 0, $urandom_range(0, 15),
                    val($urandom_range(0, 11)), 3'($urandom_range(0, 7)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule